// File: doc/BRIEF.md
# Soft-Switching Pixel Blender

This block mixes two candidate values of one 10-bit colour channel into a single softened sample. The first candidate is the plain temporal average between the two source frames (the non-motion-compensated estimate). The second is the motion-compensated estimate. The output is `w·lin + (32−w)·mc`, divided by 32. The weight `w` comes from a fixed set of four, picked per sample through a 2-bit select. A larger `w` leans on the plain average, which suits cases where the motion vectors are unreliable. `w = 16` gives an even mix.

No multiplier or divider is used. Each weighted term is built from one or two left shifts of its input, joined by a single adder/subtractor. The two terms are summed, and the five low bits of that sum are dropped to divide by 32. The result and a valid flag are registered together, one cycle after the sample is presented. The logic that judges vector reliability, and so picks the select, sits upstream and is not part of this block.

Top module: `ss_blend_top`

## Requirements
- R1: With `wsel_in` = 0, `ss_out` equals floor((24·lin + 8·mc)/32) for the sample accepted one cycle earlier.
- R2: With `wsel_in` = 1, `ss_out` equals floor((20·lin + 12·mc)/32). The 20 is formed as x·16 + x·4 and the 12 as x·16 − x·4.
- R3: With `wsel_in` = 2, `ss_out` equals floor((18·lin + 14·mc)/32).
- R4: With `wsel_in` = 3, `ss_out` equals floor((16·lin + 16·mc)/32), which is the truncated mean of the two inputs.
- R5: The division by 32 truncates: the five least significant bits of the weighted sum are discarded, never rounded.
- R6: The result never overflows and always lies between the smaller and the larger of the two inputs. Equal inputs reproduce that value, including 1023.
- R7: `out_valid` equals `in_valid` delayed by one clock, and `ss_out` takes its new value in that same cycle.
- R8: A cycle with `in_valid` low has no effect: `ss_out` keeps its previous value whatever `lin`, `mc` and `wsel_in` carry.
- R9: While `rst_n` is low at a clock edge, `out_valid` and `ss_out` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample on `lin`, `mc`, `wsel_in` is valid |
| lin | input | 10 | Non-motion-compensated (linear average) estimate |
| mc | input | 10 | Motion-compensated estimate |
| wsel_in | input | 2 | Weight pair: 0=24:8, 1=20:12, 2=18:14, 3=16:16 (weight on `lin` first) |
| out_valid | output | 1 | `ss_out` carries a new result |
| ss_out | output | 10 | Blended sample |

## Verification
Every result is due exactly one rising edge after its sample is accepted. The bench drives each sample on a falling edge and checks `ss_out` and `out_valid` on the next falling edge, before it drives the next sample. Because one sample is checked on each falling edge, samples stream back to back. The same timing is kept for the idle checks: a cycle with `in_valid` low and changed data is followed, one falling edge later, by a check that `out_valid` is low and `ss_out` is unchanged. Expected values are computed from the integer weights.

// File: rtl/ss_blend_pkg.sv
package ss_blend_pkg;

    localparam int FRAC_W = 5;
    localparam int SH_W   = 3;

    typedef enum logic [1:0] {
        W24_8  = 2'd0,
        W20_12 = 2'd1,
        W18_14 = 2'd2,
        W16_16 = 2'd3
    } wsel_e;

    typedef struct packed {
        logic [SH_W-1:0] sh_a;
        logic            use_b;
        logic [SH_W-1:0] sh_b;
        logic            sub_b;
    } shift_plan_t;

    function automatic shift_plan_t plan_for(input logic side_lin, input wsel_e sel);
        shift_plan_t p;
        p = '{sh_a: 3'd4, use_b: 1'b0, sh_b: 3'd0, sub_b: 1'b0};
        if (side_lin) begin
            unique case (sel)
                W24_8:   p = '{sh_a: 3'd4, use_b: 1'b1, sh_b: 3'd3, sub_b: 1'b0};
                W20_12:  p = '{sh_a: 3'd4, use_b: 1'b1, sh_b: 3'd2, sub_b: 1'b0};
                W18_14:  p = '{sh_a: 3'd4, use_b: 1'b1, sh_b: 3'd1, sub_b: 1'b0};
                default: p = '{sh_a: 3'd4, use_b: 1'b0, sh_b: 3'd0, sub_b: 1'b0};
            endcase
        end else begin
            unique case (sel)
                W24_8:   p = '{sh_a: 3'd3, use_b: 1'b0, sh_b: 3'd0, sub_b: 1'b0};
                W20_12:  p = '{sh_a: 3'd4, use_b: 1'b1, sh_b: 3'd2, sub_b: 1'b1};
                W18_14:  p = '{sh_a: 3'd4, use_b: 1'b1, sh_b: 3'd1, sub_b: 1'b1};
                default: p = '{sh_a: 3'd4, use_b: 1'b0, sh_b: 3'd0, sub_b: 1'b0};
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/ss_scale.sv
module ss_scale
    import ss_blend_pkg::*;
#(
    parameter int  PIX_W    = 10,
    parameter bit  SIDE_LIN = 1'b1,
    localparam int SUM_W    = PIX_W + FRAC_W
) (
    input  logic [PIX_W-1:0] x,
    input  wsel_e            sel,
    output logic [SUM_W-1:0] y
);

    shift_plan_t      plan;
    logic [SUM_W-1:0] x_ext;
    logic [SUM_W-1:0] term_a;
    logic [SUM_W-1:0] term_b;

    always_comb begin
        plan   = plan_for(SIDE_LIN, sel);
        x_ext  = {{FRAC_W{1'b0}}, x};
        term_a = x_ext << plan.sh_a;
        term_b = plan.use_b ? (x_ext << plan.sh_b) : '0;
        y      = plan.sub_b ? (term_a - term_b) : (term_a + term_b);
    end

endmodule

// File: rtl/ss_trunc.sv
module ss_trunc
    import ss_blend_pkg::*;
#(
    parameter int  PIX_W = 10,
    localparam int SUM_W = PIX_W + FRAC_W
) (
    input  logic [SUM_W-1:0] sum,
    output logic [PIX_W-1:0] q
);

    assign q = sum[SUM_W-1:FRAC_W];

endmodule

// File: rtl/ss_blend_top.sv
module ss_blend_top
    import ss_blend_pkg::*;
#(
    parameter int  PIX_W = 10,
    localparam int SUM_W = PIX_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] lin,
    input  logic [PIX_W-1:0] mc,
    input  logic [1:0]       wsel_in,
    output logic             out_valid,
    output logic [PIX_W-1:0] ss_out
);

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] ss;
    } blend_state_t;

    blend_state_t     st_d, st_q;
    wsel_e            sel;
    logic [SUM_W-1:0] lin_w, mc_w, sum_w;
    logic [PIX_W-1:0] ss_new;

    assign sel = wsel_e'(wsel_in);

    ss_scale #(.PIX_W(PIX_W), .SIDE_LIN(1'b1)) u_scale_lin (
        .x   (lin),
        .sel (sel),
        .y   (lin_w)
    );

    ss_scale #(.PIX_W(PIX_W), .SIDE_LIN(1'b0)) u_scale_mc (
        .x   (mc),
        .sel (sel),
        .y   (mc_w)
    );

    assign sum_w = lin_w + mc_w;

    ss_trunc #(.PIX_W(PIX_W)) u_trunc (
        .sum (sum_w),
        .q   (ss_new)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.ss = ss_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign ss_out    = st_q.ss;

endmodule

// File: rtl/ss_blend_chk.sv
module ss_blend_chk #(
    parameter int PIX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [PIX_W-1:0] lin,
    input logic [PIX_W-1:0] mc,
    input logic [1:0]       wsel_in,
    input logic             out_valid,
    input logic [PIX_W-1:0] ss_out
);

    assert_valid_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(ss_out));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lin == mc) |=> (ss_out == $past(lin)));

    assert_within_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((ss_out >= $past(lin) || ss_out >= $past(mc)) &&
                      (ss_out <= $past(lin) || ss_out <= $past(mc))));

    assert_even_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wsel_in == 2'd3) |=>
        ({1'b0, ss_out} == (({1'b0, $past(lin)} + {1'b0, $past(mc)}) >> 1)));

endmodule

bind ss_blend_top ss_blend_chk #(.PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .lin       (lin),
    .mc        (mc),
    .wsel_in   (wsel_in),
    .out_valid (out_valid),
    .ss_out    (ss_out)
);

// File: tb/ss_blend_top_tb_top.sv
module ss_blend_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [9:0] lin, mc;
    logic [1:0] wsel_in;
    logic       out_valid;
    logic [9:0] ss_out;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    ss_blend_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .lin       (lin),
        .mc        (mc),
        .wsel_in   (wsel_in),
        .out_valid (out_valid),
        .ss_out    (ss_out)
    );

    function automatic int lin_weight(input int s);
        case (s)
            0: return 24;
            1: return 20;
            2: return 18;
            default: return 16;
        endcase
    endfunction

    function automatic string tag_for(input int s);
        case (s)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    int  pend_exp   = 0;
    bit  pend_valid = 0;
    string pend_tag = "R7";

    task automatic drive(input int s, input int a, input int b);
        @(negedge clk);
        if (pend_valid) begin
            check(pend_tag, int'(ss_out), pend_exp);
            check("R7", int'(out_valid), 1);
        end
        in_valid = 1'b1;
        wsel_in  = 2'(s);
        lin      = 10'(a);
        mc       = 10'(b);
        pend_exp   = (lin_weight(s) * a + (32 - lin_weight(s)) * b) >>> 5;
        pend_tag   = tag_for(s);
        pend_valid = 1;
    endtask

    task automatic flush;
        @(negedge clk);
        if (pend_valid) begin
            check(pend_tag, int'(ss_out), pend_exp);
            check("R7", int'(out_valid), 1);
        end
        in_valid   = 1'b0;
        pend_valid = 0;
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b1;
        lin      = 10'd700;
        mc       = 10'd300;
        wsel_in  = 2'd0;
        repeat (3) @(negedge clk);
        check("R9", int'(out_valid), 0);
        check("R9", int'(ss_out), 0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);
        check("R7", int'(out_valid), 0);

        // R5: truncation corners
        drive(0, 1, 0);
        drive(1, 3, 1);
        drive(2, 1, 1);
        drive(3, 1, 0);
        drive(0, 5, 4);
        flush();
        begin
            int t;
            t = (24 * 1 + 8 * 0) >>> 5;
            check("R5", t, 0);
        end
        drive(1, 3, 1);
        flush();
        check("R5", int'(ss_out), 2);

        // R6: extremes, equal inputs
        for (int s = 0; s < 4; s++) begin
            drive(s, 1023, 1023);
            flush();
            check("R6", int'(ss_out), 1023);
            drive(s, 1023, 0);
            drive(s, 0, 1023);
        end
        flush();

        // Sweep all weights over a grid, back to back
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 1024; a += 31) begin
                for (int b = 0; b < 1024; b += 29) begin
                    drive(s, a, b);
                end
                drive(s, a, 1023);
            end
        end
        flush();

        // R8: idle cycles with changing inputs keep the output
        drive(2, 600, 100);
        flush();
        begin
            int held;
            held = int'(ss_out);
            check("R3", held, (18 * 600 + 14 * 100) >>> 5);
            for (int i = 0; i < 8; i++) begin
                in_valid = 1'b0;
                lin      = 10'(i * 100 + 17);
                mc       = 10'(1000 - i * 90);
                wsel_in  = 2'(i);
                @(negedge clk);
                check("R8", int'(ss_out), held);
                check("R7", int'(out_valid), 0);
            end
        end

        // R9: reset in mid-stream clears outputs
        drive(0, 900, 900);
        pend_valid = 0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", int'(out_valid), 0);
        check("R9", int'(ss_out), 0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule